// File: doc/BRIEF.md
# Software-Loaded TLB Entry Matcher

This block holds a small set of software-written translation entries, organised as several arrays of a fixed number of ways. When a lookup is requested, every entry is checked in parallel against the effective address, the current process identifiers, the privilege level and the address-space bits. A priority pick then reports the result of the first entry, in scan order, whose outcome is not a miss. Each entry's page size is a power of four times 1 KiB. The size comes either from the entry or, for arrays that do not support variable sizes, from a per-array minimum-size setting. An entry's process tag of zero matches any process.

A lookup is started with a one-cycle `start` pulse. The result code, physical address and granted permissions are registered on that same clock edge, and `done` is high for the following cycle. Entries are loaded through a write port. A flash-invalidate command clears the valid bits of all entries in a chosen set of arrays, and can optionally spare protected entries.

Top module: `mas_tlb_match`

## Requirements
- R1: After reset every entry is invalid, `done` is 0, `resCode` is 01 (miss), and `resPa` and `resPerm` are 0.
- R2: An entry whose valid bit is clear never produces a hit or a fault.
- R3: An entry's page covers 1024 × 4^s bytes. Here s is the entry's size field when `cfgVarSize[array]` is 1, and `cfgMinSize[array*4 +: 4]` when it is 0.
- R4: An entry's process tag matches when it is zero or equals `pid0`. It also matches when it equals `pid1` or `pid2`, each of which is tried only when nonzero.
- R5: An entry misses unless the effective address with its in-page bits cleared equals the entry's page number field.
- R6: On a hit or fault, `resPa` holds the real page bits above the page boundary and the effective-address bits below it.
- R7: `resPerm` = {execute, write, read}. The entry permission word is {sx, sw, sr, ux, uw, ur}. Its low three bits are granted when `userMode` is 1, and its high three bits otherwise.
- R8: The entry's address-space bit must equal `instAs` for a fetch, or `dataAs` for a read or write. A mismatch is a miss.
- R9: `accType` 00 is a read, 01 is a write, and 1x is a fetch. The result codes are 00 hit, 01 miss, 10 read/write fault and 11 execute fault. A fault still reports the granted permissions and the address. A miss reports address 0 and permissions 0.
- R10: Entries are ranked by array, then by way, lowest first. The reported result is that of the first entry whose outcome is not a miss.
- R11: Outputs are captured on the edge that samples `start` high, and `done` is high for exactly the next cycle. Without `start`, the outputs hold their values.
- R12: A flash invalidate clears the valid bit of every entry in the arrays selected by `flashSel`. When `flashKeepProt` is 1, entries whose protect bit is set are kept. In a cycle with both a flash and a write to the same entry, the flash decides the valid bit.
- R13: A write stores all entry fields at (`wrArray`, `wrWay`), and the new entry is visible to the next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Lookup request pulse |
| ea | input | 32 | Effective address |
| accType | input | 2 | Access type (00 read, 01 write, 1x fetch) |
| userMode | input | 1 | 1 = user privilege |
| instAs | input | 1 | Instruction address-space bit |
| dataAs | input | 1 | Data address-space bit |
| pid0 | input | 8 | Primary process ID |
| pid1 | input | 8 | Secondary process ID (0 = unused) |
| pid2 | input | 8 | Tertiary process ID (0 = unused) |
| cfgVarSize | input | NUM_ARRAYS | Per-array variable-size support |
| cfgMinSize | input | 4*NUM_ARRAYS | Per-array minimum size code |
| wrEn | input | 1 | Entry write strobe |
| wrArray | input | ARR_W | Target array |
| wrWay | input | WAY_W | Target way |
| wrValid | input | 1 | Entry valid bit |
| wrIprot | input | 1 | Entry protect-from-flash bit |
| wrTid | input | 8 | Entry process tag |
| wrTs | input | 1 | Entry address-space bit |
| wrTsize | input | 4 | Entry size code |
| wrEpn | input | 32 | Entry effective page number |
| wrRpn | input | 32 | Entry real page number |
| wrPerm | input | 6 | Entry permissions {sx,sw,sr,ux,uw,ur} |
| flashEn | input | 1 | Flash-invalidate strobe |
| flashSel | input | NUM_ARRAYS | Arrays to invalidate |
| flashKeepProt | input | 1 | Spare protected entries |
| done | output | 1 | Result valid strobe |
| resCode | output | 2 | Result code |
| resPa | output | 32 | Physical address |
| resPerm | output | 3 | Granted {x,w,r} |

## Verification
On every cycle, the assertions check the handshake timing: `done` follows `start` exactly, and the outputs hold when no lookup is issued. They also check that a flash with protection off leaves no valid entry in a selected array, that a miss never carries an address or permissions, and that a fetch hit always has execute permission. Only the bench's scenarios can show the translation arithmetic itself. Those scenarios cover page-size selection from the entry or the array setting, the wildcard and multi-ID tag matching, address-space gating, the fault split, and which of several overlapping entries wins.

// File: rtl/mas_tlb_pkg.sv
package mas_tlb_pkg;
  parameter int ADDR_W  = 32;
  parameter int TID_W   = 8;
  parameter int TSIZE_W = 4;
  parameter int PERM_W  = 6;

  typedef enum logic [1:0] {
    RES_HIT     = 2'b00,
    RES_MISS    = 2'b01,
    RES_RWFAULT = 2'b10,
    RES_XFAULT  = 2'b11
  } resCode_e;

  typedef struct packed {
    logic               valid;
    logic               iprot;
    logic [TID_W-1:0]   tid;
    logic               ts;
    logic [TSIZE_W-1:0] tsize;
    logic [ADDR_W-1:0]  epn;
    logic [ADDR_W-1:0]  rpn;
    logic [PERM_W-1:0]  perm;
  } tlbEntry_t;

  typedef struct packed {
    resCode_e          code;
    logic [ADDR_W-1:0] pa;
    logic [2:0]        perm;
  } lookupRes_t;

  typedef struct packed {
    logic capture;
    logic invalidate;
    logic load;
  } ctlStrobe_t;
endpackage

// File: rtl/mas_tlb_entry_check.sv
module mas_tlb_entry_check
  import mas_tlb_pkg::*;
(
  input  logic               entValid,
  input  logic [TID_W-1:0]   entTid,
  input  logic               entTs,
  input  logic [TSIZE_W-1:0] entTsize,
  input  logic [ADDR_W-1:0]  entEpn,
  input  logic [ADDR_W-1:0]  entRpn,
  input  logic [PERM_W-1:0]  entPerm,
  input  logic               varSize,
  input  logic [TSIZE_W-1:0] minSize,
  input  logic [ADDR_W-1:0]  ea,
  input  logic [TID_W-1:0]   pid0,
  input  logic [TID_W-1:0]   pid1,
  input  logic [TID_W-1:0]   pid2,
  input  logic               userMode,
  input  logic               instAs,
  input  logic               dataAs,
  input  logic [1:0]         accType,
  output lookupRes_t         res
);
  logic [TSIZE_W-1:0] effSize;
  logic [ADDR_W-1:0]  pageMask;
  logic               tidWild, pidOk, eaOk, asOk, isFetch, isWrite;
  logic [2:0]         granted;
  int                 pageBits;

  always_comb begin
    effSize  = varSize ? entTsize : minSize;
    pageBits = 10 + 2 * int'(effSize);
    for (int i = 0; i < ADDR_W; i++) pageMask[i] = (i >= pageBits);
  end

  // Tag match: tag zero is a wildcard; secondary IDs only when nonzero (R4)
  always_comb begin
    tidWild = (entTid == '0);
    pidOk   = tidWild || (entTid == pid0)
           || ((pid1 != '0) && (entTid == pid1))
           || ((pid2 != '0) && (entTid == pid2));
    eaOk    = ((ea & pageMask) == entEpn);
    isFetch = accType[1];
    isWrite = !accType[1] && accType[0];
    asOk    = (entTs == (isFetch ? instAs : dataAs));
    granted = userMode ? entPerm[2:0] : entPerm[5:3];
  end

  always_comb begin
    res.code = RES_MISS;
    res.pa   = '0;
    res.perm = '0;
    if (entValid && pidOk && eaOk && asOk) begin
      res.pa   = (entRpn & pageMask) | (ea & ~pageMask);
      res.perm = granted;
      if (isFetch)      res.code = granted[2] ? RES_HIT : RES_XFAULT;
      else if (isWrite) res.code = granted[1] ? RES_HIT : RES_RWFAULT;
      else              res.code = granted[0] ? RES_HIT : RES_RWFAULT;
    end
  end
endmodule

// File: rtl/mas_tlb_control.sv
module mas_tlb_control
  import mas_tlb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       flashEn,
  input  logic       wrEn,
  output ctlStrobe_t strb,
  output logic       done
);
  always_comb begin
    strb.capture    = start;
    strb.invalidate = flashEn;
    strb.load       = wrEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) done <= 1'b0;
    else       done <= start;
  end

  assert_done_after_start_R11: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);
  assert_no_spurious_done_R11: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done);
endmodule

// File: rtl/mas_tlb_datapath.sv
module mas_tlb_datapath
  import mas_tlb_pkg::*;
#(
  parameter int NUM_ARRAYS = 2,
  parameter int WAYS       = 4,
  localparam int ARR_W     = (NUM_ARRAYS > 1) ? $clog2(NUM_ARRAYS) : 1,
  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStrobe_t                    strb,
  input  logic [ARR_W-1:0]              wrArray,
  input  logic [WAY_W-1:0]              wrWay,
  input  tlbEntry_t                     wrEntry,
  input  logic [NUM_ARRAYS-1:0]         flashSel,
  input  logic                          flashKeepProt,
  input  logic [NUM_ARRAYS-1:0]         cfgVarSize,
  input  logic [NUM_ARRAYS*TSIZE_W-1:0] cfgMinSize,
  input  logic [ADDR_W-1:0]             ea,
  input  logic [TID_W-1:0]              pid0,
  input  logic [TID_W-1:0]              pid1,
  input  logic [TID_W-1:0]              pid2,
  input  logic                          userMode,
  input  logic                          instAs,
  input  logic                          dataAs,
  input  logic [1:0]                    accType,
  output lookupRes_t                    outRes
);
  localparam int NUM_ENTRIES = NUM_ARRAYS * WAYS;

  tlbEntry_t  entries [NUM_ARRAYS][WAYS];
  lookupRes_t perEntry [NUM_ENTRIES];
  lookupRes_t picked;

  // Entry storage: load then flash, so flash decides the valid bit (R12, R13)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < NUM_ARRAYS; a++)
        for (int w = 0; w < WAYS; w++) entries[a][w] <= '0;
    end else begin
      if (strb.load) entries[wrArray][wrWay] <= wrEntry;
      if (strb.invalidate) begin
        for (int a = 0; a < NUM_ARRAYS; a++)
          for (int w = 0; w < WAYS; w++)
            if (flashSel[a] && !(flashKeepProt && entries[a][w].iprot))
              entries[a][w].valid <= 1'b0;
      end
    end
  end

  for (genvar a = 0; a < NUM_ARRAYS; a++) begin : gArr
    for (genvar w = 0; w < WAYS; w++) begin : gWay
      mas_tlb_entry_check u_check (
        .entValid (entries[a][w].valid),
        .entTid   (entries[a][w].tid),
        .entTs    (entries[a][w].ts),
        .entTsize (entries[a][w].tsize),
        .entEpn   (entries[a][w].epn),
        .entRpn   (entries[a][w].rpn),
        .entPerm  (entries[a][w].perm),
        .varSize  (cfgVarSize[a]),
        .minSize  (cfgMinSize[a*TSIZE_W +: TSIZE_W]),
        .ea       (ea),
        .pid0     (pid0),
        .pid1     (pid1),
        .pid2     (pid2),
        .userMode (userMode),
        .instAs   (instAs),
        .dataAs   (dataAs),
        .accType  (accType),
        .res      (perEntry[a*WAYS + w])
      );

      assert_flash_clears_R12: assert property (@(posedge clk) disable iff (!rstN)
        (strb.invalidate && flashSel[a] && !flashKeepProt) |=> !entries[a][w].valid);
    end
  end

  // First non-miss in array-then-way order wins (R10)
  always_comb begin
    logic found;
    found       = 1'b0;
    picked.code = RES_MISS;
    picked.pa   = '0;
    picked.perm = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!found && perEntry[i].code != RES_MISS) begin
        picked = perEntry[i];
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outRes.code <= RES_MISS;
      outRes.pa   <= '0;
      outRes.perm <= '0;
    end else if (strb.capture) begin
      outRes <= picked;
    end
  end

  assert_miss_is_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outRes.code == RES_MISS) |-> (outRes.pa == '0 && outRes.perm == '0));
  assert_fetch_hit_exec_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && accType[1]) |=> (outRes.code != RES_HIT || outRes.perm[2]));
  assert_result_holds_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(outRes));
endmodule

// File: rtl/mas_tlb_match.sv
module mas_tlb_match
  import mas_tlb_pkg::*;
#(
  parameter int NUM_ARRAYS = 2,
  parameter int WAYS       = 4,
  localparam int ARR_W     = (NUM_ARRAYS > 1) ? $clog2(NUM_ARRAYS) : 1,
  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic [ADDR_W-1:0]             ea,
  input  logic [1:0]                    accType,
  input  logic                          userMode,
  input  logic                          instAs,
  input  logic                          dataAs,
  input  logic [TID_W-1:0]              pid0,
  input  logic [TID_W-1:0]              pid1,
  input  logic [TID_W-1:0]              pid2,
  input  logic [NUM_ARRAYS-1:0]         cfgVarSize,
  input  logic [NUM_ARRAYS*TSIZE_W-1:0] cfgMinSize,
  input  logic                          wrEn,
  input  logic [ARR_W-1:0]              wrArray,
  input  logic [WAY_W-1:0]              wrWay,
  input  logic                          wrValid,
  input  logic                          wrIprot,
  input  logic [TID_W-1:0]              wrTid,
  input  logic                          wrTs,
  input  logic [TSIZE_W-1:0]            wrTsize,
  input  logic [ADDR_W-1:0]             wrEpn,
  input  logic [ADDR_W-1:0]             wrRpn,
  input  logic [PERM_W-1:0]             wrPerm,
  input  logic                          flashEn,
  input  logic [NUM_ARRAYS-1:0]         flashSel,
  input  logic                          flashKeepProt,
  output logic                          done,
  output logic [1:0]                    resCode,
  output logic [ADDR_W-1:0]             resPa,
  output logic [2:0]                    resPerm
);
  ctlStrobe_t strb;
  tlbEntry_t  wrEntry;
  lookupRes_t outRes;

  always_comb begin
    wrEntry.valid = wrValid;
    wrEntry.iprot = wrIprot;
    wrEntry.tid   = wrTid;
    wrEntry.ts    = wrTs;
    wrEntry.tsize = wrTsize;
    wrEntry.epn   = wrEpn;
    wrEntry.rpn   = wrRpn;
    wrEntry.perm  = wrPerm;
  end

  mas_tlb_control u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .flashEn (flashEn),
    .wrEn    (wrEn),
    .strb    (strb),
    .done    (done)
  );

  mas_tlb_datapath #(.NUM_ARRAYS(NUM_ARRAYS), .WAYS(WAYS)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .wrArray       (wrArray),
    .wrWay         (wrWay),
    .wrEntry       (wrEntry),
    .flashSel      (flashSel),
    .flashKeepProt (flashKeepProt),
    .cfgVarSize    (cfgVarSize),
    .cfgMinSize    (cfgMinSize),
    .ea            (ea),
    .pid0          (pid0),
    .pid1          (pid1),
    .pid2          (pid2),
    .userMode      (userMode),
    .instAs        (instAs),
    .dataAs        (dataAs),
    .accType       (accType),
    .outRes        (outRes)
  );

  assign resCode = outRes.code;
  assign resPa   = outRes.pa;
  assign resPerm = outRes.perm;
endmodule

// File: tb/mas_tlb_match_tb.sv
module mas_tlb_match_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic        start = 0;
  logic [31:0] ea = 0;
  logic [1:0]  accType = 0;
  logic        userMode = 0, instAs = 0, dataAs = 0;
  logic [7:0]  pid0 = 0, pid1 = 0, pid2 = 0;
  logic [1:0]  cfgVarSize = 2'b01;
  logic [7:0]  cfgMinSize = 8'h10;
  logic        wrEn = 0;
  logic [0:0]  wrArray = 0;
  logic [1:0]  wrWay = 0;
  logic        wrValid = 0, wrIprot = 0, wrTs = 0;
  logic [7:0]  wrTid = 0;
  logic [3:0]  wrTsize = 0;
  logic [31:0] wrEpn = 0, wrRpn = 0;
  logic [5:0]  wrPerm = 0;
  logic        flashEn = 0;
  logic [1:0]  flashSel = 0;
  logic        flashKeepProt = 0;
  logic        done;
  logic [1:0]  resCode;
  logic [31:0] resPa;
  logic [2:0]  resPerm;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mas_tlb_match u_dut (.*);

  typedef struct packed {
    logic [31:0] ea;
    logic [1:0]  acc;
    logic        user;
    logic [1:0]  code;
    logic [31:0] pa;
    logic [2:0]  perm;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1234, 2'b00, 1'b0, 2'b00, 32'h8000_0234, 3'b111, 8'd6},  // R6 1 KiB hit
    '{32'h0000_1234, 2'b01, 1'b1, 2'b10, 32'h8000_0234, 3'b001, 8'd9},  // R9 user write fault
    '{32'h0000_1800, 2'b00, 1'b1, 2'b00, 32'h0090_0800, 3'b111, 8'd10}, // R10 falls to array 1
    '{32'h0010_2ABC, 2'b00, 1'b1, 2'b00, 32'h2340_2ABC, 3'b011, 8'd4},  // R4 tag via pid2
    '{32'h0010_3000, 2'b10, 1'b0, 2'b11, 32'h2340_3000, 3'b011, 8'd9},  // R9 exec fault
    '{32'h0010_4000, 2'b00, 1'b0, 2'b01, 32'h0,         3'b000, 8'd5},  // R5 outside page
    '{32'h0020_0010, 2'b00, 1'b0, 2'b01, 32'h0,         3'b000, 8'd8},  // R8 space mismatch
    '{32'h0030_0010, 2'b00, 1'b0, 2'b01, 32'h0,         3'b000, 8'd2},  // R2 invalid entry
    '{32'h0040_0FFC, 2'b01, 1'b0, 2'b00, 32'h0070_0FFC, 3'b111, 8'd3},  // R3 fixed 4 KiB
    '{32'h0040_1000, 2'b01, 1'b0, 2'b01, 32'h0,         3'b000, 8'd3},  // R3 not 64 KiB
    '{32'h0000_1400, 2'b00, 1'b0, 2'b00, 32'h0090_0400, 3'b111, 8'd5}   // R5/R10
  };

  task automatic check(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  task automatic writeEntry(input logic a, input logic [1:0] w, input logic v,
                            input logic ip, input logic [7:0] tid, input logic ts,
                            input logic [3:0] sz, input logic [31:0] epn,
                            input logic [31:0] rpn, input logic [5:0] pm);
    @(negedge clk);
    wrEn = 1; wrArray = a; wrWay = w; wrValid = v; wrIprot = ip; wrTid = tid;
    wrTs = ts; wrTsize = sz; wrEpn = epn; wrRpn = rpn; wrPerm = pm;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic flash(input logic [1:0] sel, input logic keep);
    @(negedge clk);
    flashEn = 1; flashSel = sel; flashKeepProt = keep;
    @(negedge clk);
    flashEn = 0;
  endtask

  task automatic lookup(input logic [31:0] a, input logic [1:0] acc, input logic u,
                        input logic [1:0] c, input logic [31:0] p, input logic [2:0] pm,
                        input string req);
    @(negedge clk);
    ea = a; accType = acc; userMode = u; start = 1;
    @(negedge clk);
    start = 0;
    check(done === 1'b1 && resCode === c && resPa === p && resPerm === pm, req,
          $sformatf("ea=%h done=%b code=%b pa=%h perm=%b exp code=%b pa=%h perm=%b",
                    a, done, resCode, resPa, resPerm, c, p, pm));
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(done === 0 && resCode === 2'b01 && resPa === 0 && resPerm === 0, "R1",
          $sformatf("done=%b code=%b pa=%h perm=%b exp 0 01 0 0", done, resCode, resPa, resPerm));
    lookup(32'h0000_0000, 2'b00, 0, 2'b01, 0, 0, "R1");

    // R13 loading entries
    writeEntry(0, 0, 1, 0, 8'd0, 0, 4'd0, 32'h0000_1000, 32'h8000_0000, 6'b111_001);
    writeEntry(0, 1, 1, 0, 8'd7, 0, 4'd2, 32'h0010_0000, 32'h2340_0000, 6'b011_011);
    writeEntry(0, 2, 1, 0, 8'd0, 1, 4'd1, 32'h0020_0000, 32'h0050_0000, 6'b111_111);
    writeEntry(0, 3, 0, 0, 8'd0, 0, 4'd1, 32'h0030_0000, 32'h0060_0000, 6'b111_111);
    writeEntry(1, 0, 1, 1, 8'd0, 0, 4'd3, 32'h0040_0000, 32'h0070_0000, 6'b111_111);
    writeEntry(1, 1, 1, 0, 8'd0, 0, 4'd0, 32'h0000_1000, 32'h0090_0000, 6'b111_111);

    pid0 = 8'd3; pid1 = 8'd0; pid2 = 8'd7;
    for (int i = 0; i < NV; i++)
      lookup(VECS[i].ea, VECS[i].acc, VECS[i].user, VECS[i].code, VECS[i].pa,
             VECS[i].perm, $sformatf("R%0d", VECS[i].req));

    // R11 done lasts one cycle, result holds
    @(negedge clk);
    check(done === 0 && resCode === 2'b00 && resPa === 32'h0090_0400, "R11",
          $sformatf("done=%b code=%b pa=%h exp 0 00 00900400", done, resCode, resPa));

    // R4 tag matching across IDs
    pid2 = 8'd0;
    lookup(32'h0010_2ABC, 2'b00, 1, 2'b01, 0, 0, "R4");
    pid1 = 8'd7;
    lookup(32'h0010_2ABC, 2'b00, 1, 2'b00, 32'h2340_2ABC, 3'b011, "R4");
    pid0 = 8'd7; pid1 = 8'd0;
    lookup(32'h0010_2ABC, 2'b00, 1, 2'b00, 32'h2340_2ABC, 3'b011, "R4");

    // R8 address-space selection
    dataAs = 1;
    lookup(32'h0020_0010, 2'b00, 0, 2'b00, 32'h0050_0010, 3'b111, "R8");
    dataAs = 0; instAs = 1;
    lookup(32'h0000_1234, 2'b10, 0, 2'b01, 0, 0, "R8");
    instAs = 0;
    lookup(32'h0000_1234, 2'b10, 0, 2'b00, 32'h8000_0234, 3'b111, "R7");

    // R12 flash keeping protected entries
    flash(2'b10, 1);
    lookup(32'h0040_0010, 2'b00, 0, 2'b00, 32'h0070_0010, 3'b111, "R12");
    lookup(32'h0000_1800, 2'b00, 1, 2'b01, 0, 0, "R12");
    lookup(32'h0000_1234, 2'b00, 0, 2'b00, 32'h8000_0234, 3'b111, "R12");
    flash(2'b11, 0);
    lookup(32'h0040_0010, 2'b00, 0, 2'b01, 0, 0, "R12");
    lookup(32'h0000_1234, 2'b00, 0, 2'b01, 0, 0, "R12");

    // R12 flash beats a same-cycle write
    @(negedge clk);
    wrEn = 1; wrArray = 0; wrWay = 0; wrValid = 1; wrIprot = 0; wrTid = 0; wrTs = 0;
    wrTsize = 0; wrEpn = 32'h0000_1000; wrRpn = 32'h8000_0000; wrPerm = 6'b111_001;
    flashEn = 1; flashSel = 2'b01; flashKeepProt = 0;
    @(negedge clk);
    wrEn = 0; flashEn = 0;
    lookup(32'h0000_1234, 2'b00, 0, 2'b01, 0, 0, "R12");
    writeEntry(0, 0, 1, 0, 8'd0, 0, 4'd0, 32'h0000_1000, 32'h8000_0000, 6'b111_001);
    lookup(32'h0000_1234, 2'b00, 0, 2'b00, 32'h8000_0234, 3'b111, "R13");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule